// File: doc/BRIEF.md
# Receive Descriptor DMA Controller

This block is the control engine that empties an on-chip receive FIFO into host memory. Host buffers are described by a singly linked chain of descriptors. Each descriptor is three words: a link to the next descriptor, a command/status word whose low 16 bits give the buffer size, and a buffer pointer. When the driver raises the enable command, the engine reads the descriptor at the current descriptor pointer into a one-entry cache in a single 12-byte burst. It then waits until the FIFO holds a finished packet, or holds more bytes of the current packet than a drain threshold. It drains the data into the buffer through a plain request/done bus-master handshake and finally writes a status word back to the descriptor.

After a status write the pointer follows the cached link. A zero link parks the engine in idle with a completion flag set and the enable bit cleared. A later enable then re-reads only the link word of the finished descriptor, so the driver can append descriptors to the chain. A packet that does not fit the buffer is written up to the buffer size and flagged as overflowed. Its remaining bytes are thrown away as they arrive from the MAC. The MAC fill side is modelled as a byte strobe and a packet-end strobe, and the FIFO is modelled by its occupancy counters.

Top module: `rxDescDma`

## Requirements
- R1: After reset no bus request is raised, the descriptor pointer is 0, the completion flag and the enable bit are 0, and both FIFO counters are 0.
- R2: An enable pulse while idle with the completion flag clear sets the enable bit and issues a descriptor read (busOp 0) at the descriptor pointer with length 12. The returned link, size (low 16 bits of the command word) and buffer pointer are cached.
- R3: With a descriptor cached, no data write is issued until the packet count is non-zero or the current-packet byte count exceeds DRAIN_THR. Exactly DRAIN_THR bytes are not enough.
- R4: A data write (busOp 2) targets the buffer pointer plus the bytes already stored in this descriptor. Its length is the smaller of the FIFO's current-packet bytes and the bytes left in the buffer. The request and its address stay stable until done.
- R5: The status write (busOp 3) targets descriptor pointer + 4. Its word has bit 31 = 1 (ownership returned to the driver), bit 30 = overflow, and bits 15:0 = bytes stored.
- R6: After the status write completes with a non-zero cached link, the descriptor pointer takes the link, the completion flag is clear, and the next descriptor read goes to that link.
- R7: After the status write completes with a zero link, the engine goes idle with the completion flag set, the enable bit clear and the pointer unchanged.
- R8: An enable while the completion flag is set issues a link read (busOp 1, length 4) at the pointer. A non-zero result loads the pointer, clears the flag and reads that descriptor. A zero result returns to idle with the enable bit clear and the flag still set.
- R9: A driver pointer write loads the pointer and clears the completion flag.
- R10: The packet count rises on a MAC packet end and falls when a packet is finished. Both in one cycle leave it unchanged.
- R11: The current-packet byte count saturates at FIFO_DEPTH.
- R12: A packet longer than the remaining buffer is stored up to the buffer size, with the overflow bit set. Its later bytes are ignored, and its packet end does not count as a packet.
- R13: A packet still arriving is drained in several data writes, and the stored byte count accumulates across them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnSet | input | 1 | Driver pulse that sets the receive enable bit |
| ptrWr | input | 1 | Driver write strobe for the descriptor pointer |
| ptrWrData | input | 32 | New descriptor pointer value |
| macByte | input | 1 | MAC wrote one byte into the FIFO |
| macPktEnd | input | 1 | MAC finished a packet |
| busReq | output | 1 | Bus transfer request, held until busDone |
| busOp | output | 2 | 0 descriptor read, 1 link read, 2 data write, 3 status write |
| busAddr | output | 32 | Transfer start address |
| busLen | output | 16 | Transfer length in bytes |
| busWdata | output | 32 | Status word for a status write, else 0 |
| busDone | input | 1 | One-cycle transfer completion |
| rdLink | input | 32 | Link word returned by a read, valid with busDone |
| rdBufSize | input | 16 | Buffer size from the command word, valid with busDone |
| rdPtr | input | 32 | Buffer pointer returned by a descriptor read |
| curDescPtr | output | 32 | Current descriptor pointer |
| descDone | output | 1 | Completion flag |
| rxEnabled | output | 1 | Receive enable bit |
| fifoPktCnt | output | PKT_CNT_W | Complete packets in the FIFO |
| fifoCurBytes | output | $clog2(FIFO_DEPTH+1) | Bytes of the current packet present in the FIFO |

## Verification
A single cycle can carry both the completion of a data write that finishes a packet, which decrements the packet count, and a MAC packet end, which increments it. The bench provokes this by watching for the data-write request after the clock edge. It then raises the packet end on the same falling edge at which its bus model asserts done. The packet count must still read one afterwards, and a follow-up zero-length drain must consume that remaining packet. A second overlap, between a data-write completion that declares overflow and MAC bytes still arriving, is judged by both FIFO counters reading zero once the discarded packet's end has passed.

// File: rtl/rxdma_pkg.sv
`timescale 1ns/1ps
package rxdma_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 16;

  localparam logic [1:0] OP_DESC = 2'd0;
  localparam logic [1:0] OP_LINK = 2'd1;
  localparam logic [1:0] OP_DATA = 2'd2;
  localparam logic [1:0] OP_STAT = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REFR, ST_DREAD, ST_BLOCK, ST_FRAG, ST_STAT
  } rxState_e;

  typedef struct packed {
    logic descLoad;   // cache the fetched descriptor
    logic linkLoad;   // refresh read returned a usable link
    logic fragStart;  // latch fragment length and outcome
    logic fragDone;   // data write finished
    logic pktEnd;     // fragment closed the packet
    logic ovf;        // fragment exhausted the buffer
    logic statDone;   // status write finished
    logic enClr;      // stop: chain ended
  } rxStrobe_t;
endpackage

// File: rtl/rxDmaCtrl.sv
`timescale 1ns/1ps
module rxDmaCtrl
  import rxdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEn,
  input  logic       descDone,
  input  logic       fifoReady,
  input  logic       fragLast,
  input  logic       fragOvf,
  input  logic       linkZero,
  input  logic       rdLinkZero,
  input  logic       busDone,
  output rxState_e   state,
  output rxStrobe_t  strb
);
  rxState_e nextState;

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_IDLE:  if (rxEn) nextState = descDone ? ST_REFR : ST_DREAD;
      ST_REFR:  if (busDone) begin
        if (rdLinkZero) begin
          strb.enClr = 1'b1;
          nextState  = ST_IDLE;
        end else begin
          strb.linkLoad = 1'b1;
          nextState     = ST_DREAD;
        end
      end
      ST_DREAD: if (busDone) begin
        strb.descLoad = 1'b1;
        nextState     = ST_BLOCK;
      end
      ST_BLOCK: if (fifoReady) begin
        strb.fragStart = 1'b1;
        nextState      = ST_FRAG;
      end
      ST_FRAG:  if (busDone) begin
        strb.fragDone = 1'b1;
        if (fragLast) begin
          strb.pktEnd = 1'b1;
          nextState   = ST_STAT;
        end else if (fragOvf) begin
          strb.ovf  = 1'b1;
          nextState = ST_STAT;
        end else begin
          nextState = ST_BLOCK;
        end
      end
      ST_STAT:  if (busDone) begin
        strb.statDone = 1'b1;
        if (linkZero) begin
          strb.enClr = 1'b1;
          nextState  = ST_IDLE;
        end else begin
          nextState  = ST_DREAD;
        end
      end
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/rxDmaPath.sv
`timescale 1ns/1ps
module rxDmaPath
  import rxdma_pkg::*;
#(
  parameter  int FIFO_DEPTH = 64,
  parameter  int DRAIN_THR  = 16,
  parameter  int PKT_CNT_W  = 4,
  localparam int BYTE_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxState_e             state,
  input  rxStrobe_t            strb,
  input  logic                 rxEnSet,
  input  logic                 ptrWr,
  input  logic [WORD_W-1:0]    ptrWrData,
  input  logic                 macByte,
  input  logic                 macPktEnd,
  input  logic [WORD_W-1:0]    rdLink,
  input  logic [LEN_W-1:0]     rdBufSize,
  input  logic [WORD_W-1:0]    rdPtr,
  output logic                 rxEn,
  output logic                 descDone,
  output logic [WORD_W-1:0]    descPtr,
  output logic [PKT_CNT_W-1:0] pktCnt,
  output logic [BYTE_W-1:0]    curBytes,
  output logic                 fifoReady,
  output logic                 fragLast,
  output logic                 fragOvf,
  output logic                 linkZero,
  output logic                 rdLinkZero,
  output logic                 busReq,
  output logic [1:0]           busOp,
  output logic [WORD_W-1:0]    busAddr,
  output logic [LEN_W-1:0]     busLen,
  output logic [WORD_W-1:0]    busWdata
);
  localparam logic [BYTE_W:0] CAP = (BYTE_W+1)'(FIFO_DEPTH);

  logic [WORD_W-1:0] cLink, fragPtr;
  logic [LEN_W-1:0]  remaining, stored, fragLen, curExt;
  logic              statOvf, discard;
  logic              pktInc, pktDec, followLink;
  logic [BYTE_W:0]   bytesSum;
  logic [BYTE_W-1:0] bytesNext;

  assign curExt     = LEN_W'(curBytes);
  assign fifoReady  = (pktCnt != '0) || (curBytes > BYTE_W'(DRAIN_THR));
  assign linkZero   = (cLink == '0);
  assign rdLinkZero = (rdLink == '0);
  assign followLink = strb.statDone && !linkZero;

  // packet counter: MAC fill side up, engine down
  assign pktInc = macPktEnd && !discard && !(strb.ovf && pktCnt == '0);
  assign pktDec = strb.pktEnd || (strb.ovf && pktCnt != '0);

  always_comb begin
    bytesSum = {1'b0, curBytes};
    if (strb.fragDone)        bytesSum = bytesSum - {1'b0, fragLen[BYTE_W-1:0]};
    if (macByte && !discard)  bytesSum = bytesSum + 1'b1;
    bytesNext = (bytesSum > CAP) ? CAP[BYTE_W-1:0] : bytesSum[BYTE_W-1:0];
    if (strb.ovf) bytesNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxEn      <= 1'b0;
      descDone  <= 1'b0;
      descPtr   <= '0;
      cLink     <= '0;
      fragPtr   <= '0;
      remaining <= '0;
      stored    <= '0;
      statOvf   <= 1'b0;
      fragLen   <= '0;
      fragLast  <= 1'b0;
      fragOvf   <= 1'b0;
      pktCnt    <= '0;
      curBytes  <= '0;
      discard   <= 1'b0;
    end else begin
      if (rxEnSet)         rxEn <= 1'b1;
      else if (strb.enClr) rxEn <= 1'b0;

      if (ptrWr)               descPtr <= ptrWrData;
      else if (strb.linkLoad)  descPtr <= rdLink;
      else if (followLink)     descPtr <= cLink;

      if (ptrWr || strb.linkLoad || followLink) descDone <= 1'b0;
      else if (strb.statDone)                   descDone <= 1'b1;

      if (strb.descLoad) begin
        cLink     <= rdLink;
        remaining <= rdBufSize;
        fragPtr   <= rdPtr;
        stored    <= '0;
        statOvf   <= 1'b0;
      end else if (strb.fragDone) begin
        remaining <= remaining - fragLen;
        fragPtr   <= fragPtr + WORD_W'(fragLen);
        stored    <= stored + fragLen;
        if (strb.ovf) statOvf <= 1'b1;
      end

      if (strb.fragStart) begin
        fragLen  <= (curExt < remaining) ? curExt : remaining;
        fragLast <= (pktCnt != '0) && (curExt <= remaining);
        fragOvf  <= (curExt >= remaining);
      end

      pktCnt   <= pktCnt + PKT_CNT_W'(pktInc) - PKT_CNT_W'(pktDec);
      curBytes <= bytesNext;

      if (strb.ovf && pktCnt == '0 && !macPktEnd) discard <= 1'b1;
      else if (macPktEnd && discard)              discard <= 1'b0;
    end
  end

  always_comb begin
    busReq   = 1'b1;
    busOp    = OP_DESC;
    busAddr  = descPtr;
    busLen   = '0;
    busWdata = '0;
    unique case (state)
      ST_REFR:  begin busOp = OP_LINK; busLen = LEN_W'(4); end
      ST_DREAD: begin busOp = OP_DESC; busLen = LEN_W'(12); end
      ST_FRAG:  begin busOp = OP_DATA; busAddr = fragPtr; busLen = fragLen; end
      ST_STAT:  begin
        busOp    = OP_STAT;
        busAddr  = descPtr + WORD_W'(4);
        busLen   = LEN_W'(4);
        busWdata = {1'b1, statOvf, {(WORD_W-2-LEN_W){1'b0}}, stored};
      end
      default:  busReq = 1'b0;
    endcase
  end
endmodule

// File: rtl/rxDescDma.sv
`timescale 1ns/1ps
module rxDescDma
  import rxdma_pkg::*;
#(
  parameter  int FIFO_DEPTH = 64,
  parameter  int DRAIN_THR  = 16,
  parameter  int PKT_CNT_W  = 4,
  localparam int BYTE_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxEnSet,
  input  logic                 ptrWr,
  input  logic [31:0]          ptrWrData,
  input  logic                 macByte,
  input  logic                 macPktEnd,
  output logic                 busReq,
  output logic [1:0]           busOp,
  output logic [31:0]          busAddr,
  output logic [15:0]          busLen,
  output logic [31:0]          busWdata,
  input  logic                 busDone,
  input  logic [31:0]          rdLink,
  input  logic [15:0]          rdBufSize,
  input  logic [31:0]          rdPtr,
  output logic [31:0]          curDescPtr,
  output logic                 descDone,
  output logic                 rxEnabled,
  output logic [PKT_CNT_W-1:0] fifoPktCnt,
  output logic [BYTE_W-1:0]    fifoCurBytes
);
  rxState_e  state;
  rxStrobe_t strb;
  logic      fifoReady, fragLast, fragOvf, linkZero, rdLinkZero;

  rxDmaCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxEn(rxEnabled), .descDone(descDone),
    .fifoReady(fifoReady), .fragLast(fragLast), .fragOvf(fragOvf),
    .linkZero(linkZero), .rdLinkZero(rdLinkZero), .busDone(busDone),
    .state(state), .strb(strb)
  );

  rxDmaPath #(.FIFO_DEPTH(FIFO_DEPTH), .DRAIN_THR(DRAIN_THR), .PKT_CNT_W(PKT_CNT_W)) u_path (
    .clk(clk), .rstN(rstN), .state(state), .strb(strb),
    .rxEnSet(rxEnSet), .ptrWr(ptrWr), .ptrWrData(ptrWrData),
    .macByte(macByte), .macPktEnd(macPktEnd),
    .rdLink(rdLink), .rdBufSize(rdBufSize), .rdPtr(rdPtr),
    .rxEn(rxEnabled), .descDone(descDone), .descPtr(curDescPtr),
    .pktCnt(fifoPktCnt), .curBytes(fifoCurBytes), .fifoReady(fifoReady),
    .fragLast(fragLast), .fragOvf(fragOvf), .linkZero(linkZero),
    .rdLinkZero(rdLinkZero), .busReq(busReq), .busOp(busOp),
    .busAddr(busAddr), .busLen(busLen), .busWdata(busWdata)
  );
endmodule

// File: rtl/rxDescDmaChk.sv
`timescale 1ns/1ps
module rxDescDmaChk #(
  parameter  int FIFO_DEPTH = 64,
  parameter  int DRAIN_THR  = 16,
  parameter  int PKT_CNT_W  = 4,
  localparam int BYTE_W     = $clog2(FIFO_DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 ptrWr,
  input logic [31:0]          ptrWrData,
  input logic                 busReq,
  input logic [1:0]           busOp,
  input logic [31:0]          busAddr,
  input logic [31:0]          busWdata,
  input logic                 busDone,
  input logic [31:0]          curDescPtr,
  input logic                 descDone,
  input logic                 rxEnabled,
  input logic [PKT_CNT_W-1:0] fifoPktCnt,
  input logic [BYTE_W-1:0]    fifoCurBytes
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busDone |=> busReq && $stable(busOp) && $stable(busAddr)); // R4

  AST_DRAIN_GATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) && busOp == 2'd2 |->
      ($past(fifoPktCnt) != '0 || $past(fifoCurBytes) > BYTE_W'(DRAIN_THR))); // R3

  AST_OWN_RETURNED: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busOp == 2'd3 |-> busWdata[31]); // R5

  AST_BYTES_CAPPED: assert property (@(posedge clk) disable iff (!rstN)
    fifoCurBytes <= BYTE_W'(FIFO_DEPTH)); // R11

  AST_STOP_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxEnabled) |-> descDone); // R7

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ptrWr && !busReq |=> !descDone && curDescPtr == $past(ptrWrData)); // R9
endmodule

bind rxDescDma rxDescDmaChk #(.FIFO_DEPTH(FIFO_DEPTH), .DRAIN_THR(DRAIN_THR), .PKT_CNT_W(PKT_CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .ptrWr(ptrWr), .ptrWrData(ptrWrData),
  .busReq(busReq), .busOp(busOp), .busAddr(busAddr), .busWdata(busWdata),
  .busDone(busDone), .curDescPtr(curDescPtr), .descDone(descDone),
  .rxEnabled(rxEnabled), .fifoPktCnt(fifoPktCnt), .fifoCurBytes(fifoCurBytes)
);

// File: tb/rxDescDma_bench.sv
`timescale 1ns/1ps
module rxDescDma_bench;
  localparam int FIFO_DEPTH = 64;
  localparam int DRAIN_THR  = 16;
  localparam int PKT_CNT_W  = 4;
  localparam int BYTE_W     = $clog2(FIFO_DEPTH + 1);
  localparam int LOG_N      = 512;

  // {buffer size, packet length, expected status word}
  localparam logic [63:0] VEC [6] = '{
    {16'd64,  16'd10, 32'h8000_000A},
    {16'd12,  16'd12, 32'h8000_000C},
    {16'd100, 16'd40, 32'h8000_0028},
    {16'd8,   16'd30, 32'hC000_0008},
    {16'd20,  16'd5,  32'h8000_0005},
    {16'h200, 16'd90, 32'h8000_005A}
  };

  logic clk = 1'b0;
  logic rstN, rxEnSet, ptrWr, macByte, macPktEnd, busDone;
  logic [31:0] ptrWrData, rdLink, rdPtr, busAddr, busWdata, curDescPtr;
  logic [15:0] rdBufSize, busLen;
  logic [1:0]  busOp;
  logic        busReq, descDone, rxEnabled;
  logic [PKT_CNT_W-1:0] fifoPktCnt;
  logic [BYTE_W-1:0]    fifoCurBytes;

  int nChk = 0;
  int nFail = 0;
  logic [1:0]  logOp   [LOG_N];
  logic [31:0] logAddr [LOG_N];
  logic [15:0] logLen  [LOG_N];
  logic [31:0] logW    [LOG_N];
  int          logN = 0;
  logic [31:0] extraLink = 32'h0;
  logic [15:0] bufSize = 16'd64;

  always #4 clk = ~clk;

  rxDescDma #(.FIFO_DEPTH(FIFO_DEPTH), .DRAIN_THR(DRAIN_THR), .PKT_CNT_W(PKT_CNT_W)) u_rxDescDma (
    .clk(clk), .rstN(rstN), .rxEnSet(rxEnSet), .ptrWr(ptrWr), .ptrWrData(ptrWrData),
    .macByte(macByte), .macPktEnd(macPktEnd), .busReq(busReq), .busOp(busOp),
    .busAddr(busAddr), .busLen(busLen), .busWdata(busWdata), .busDone(busDone),
    .rdLink(rdLink), .rdBufSize(rdBufSize), .rdPtr(rdPtr), .curDescPtr(curDescPtr),
    .descDone(descDone), .rxEnabled(rxEnabled), .fifoPktCnt(fifoPktCnt),
    .fifoCurBytes(fifoCurBytes)
  );

  function automatic logic [31:0] linkFor(input logic [31:0] a);
    if (a == 32'h1000) return 32'h2000;
    if (a == 32'h2000) return extraLink;
    return 32'h0;
  endfunction

  // bus model: answers every request on the first falling edge it is seen
  initial begin
    busDone = 1'b0; rdLink = '0; rdBufSize = '0; rdPtr = '0;
    forever begin
      @(negedge clk);
      if (busDone) busDone = 1'b0;
      else if (busReq && rstN) begin
        logOp[logN] = busOp; logAddr[logN] = busAddr;
        logLen[logN] = busLen; logW[logN] = busWdata;
        if (logN < LOG_N - 1) logN = logN + 1;
        rdLink    = linkFor(busAddr);
        rdBufSize = bufSize;
        rdPtr     = busAddr + 32'h1_0000;
        busDone   = 1'b1;
      end
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL R2 watchdog expired act=running exp=finished");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBytes(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); macByte = 1'b1; end
    @(negedge clk); macByte = 1'b0;
  endtask

  task automatic endPkt();
    @(negedge clk); macPktEnd = 1'b1;
    @(negedge clk); macPktEnd = 1'b0;
  endtask

  task automatic loadPtr(input logic [31:0] a);
    @(negedge clk); ptrWr = 1'b1; ptrWrData = a;
    @(negedge clk); ptrWr = 1'b0;
  endtask

  task automatic enable();
    @(negedge clk); rxEnSet = 1'b1;
    @(negedge clk); rxEnSet = 1'b0;
  endtask

  task automatic waitStop(input string tag);
    int t = 0;
    while (rxEnabled && t < 2000) begin @(negedge clk); t++; end
    tick(2);
    chk(tag, 32'(t < 2000), 32'd1);
  endtask

  function automatic int lastStat(input int base);
    int r = base;
    for (int k = base; k < logN; k++) if (logOp[k] == 2'd3) r = k;
    return r;
  endfunction

  initial begin
    int base, st, fragSum, fragCnt, fragFirst;
    logic [31:0] addr;
    rstN = 1'b0; rxEnSet = 0; ptrWr = 0; ptrWrData = '0; macByte = 0; macPktEnd = 0;
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 busReq",     32'(busReq), 0);
    chk("R1 descPtr",    curDescPtr, 0);
    chk("R1 descDone",   32'(descDone), 0);
    chk("R1 rxEnabled",  32'(rxEnabled), 0);
    chk("R1 pktCnt",     32'(fifoPktCnt), 0);
    chk("R1 curBytes",   32'(fifoCurBytes), 0);

    // table of single-packet, single-descriptor cases
    for (int i = 0; i < 6; i++) begin
      addr    = 32'h4000 + 32'(i) * 32'h100;
      bufSize = VEC[i][63:48];
      base    = logN;
      loadPtr(addr);
      chk("R9 flag cleared by pointer write", 32'(descDone), 0);
      enable();
      sendBytes(int'(VEC[i][47:32]));
      endPkt();
      waitStop("R7 engine stops");
      chk("R2 first op is descriptor read", 32'(logOp[base]), 0);
      chk("R2 descriptor read address",     logAddr[base], addr);
      chk("R2 descriptor read length",      32'(logLen[base]), 12);
      st = lastStat(base);
      chk("R5 status op",      32'(logOp[st]), 3);
      chk("R5 status address", logAddr[st], addr + 32'd4);
      chk("R5 R12 status word", logW[st], VEC[i][31:0]);
      fragSum = 0; fragCnt = 0; fragFirst = -1;
      for (int k = base; k < logN; k++)
        if (logOp[k] == 2'd2) begin
          if (fragFirst < 0) fragFirst = k;
          fragSum += int'(logLen[k]); fragCnt++;
        end
      chk("R4 stored bytes equal data written", 32'(fragSum), 32'(VEC[i][15:0]));
      if (fragFirst >= 0) chk("R4 first data address", logAddr[fragFirst], addr + 32'h1_0000);
      if (VEC[i][47:32] > 16'(DRAIN_THR + 1) && VEC[i][47:32] <= VEC[i][63:48])
        chk("R13 packet drained in pieces", 32'(fragCnt >= 2), 1);
      chk("R12 pktCnt empty after packet", 32'(fifoPktCnt), 0);
      chk("R12 curBytes empty after packet", 32'(fifoCurBytes), 0);
      chk("R7 flag set at chain end", 32'(descDone), 1);
      chk("R7 pointer unchanged", curDescPtr, addr);
    end

    // R3 threshold boundary
    bufSize = 16'd64;
    base = logN;
    loadPtr(32'h5000);
    enable();
    tick(4);
    sendBytes(DRAIN_THR);
    tick(4);
    chk("R3 no drain at threshold", 32'(busReq), 0);
    chk("R3 only descriptor read so far", 32'(logN - base), 1);
    sendBytes(1);
    tick(3);
    chk("R3 drain past threshold op", 32'(logOp[base+1]), 2);
    chk("R4 drain length is bytes present", 32'(logLen[base+1]), DRAIN_THR + 1);
    endPkt();
    waitStop("R3 stop");
    chk("R13 stored accumulates", logW[lastStat(base)], 32'h8000_0011);

    // R11 saturation while disabled, then drain it
    sendBytes(70);
    chk("R11 byte count saturates", 32'(fifoCurBytes), FIFO_DEPTH);
    endPkt();
    chk("R10 packet end counted", 32'(fifoPktCnt), 1);
    bufSize = 16'd128;
    base = logN;
    loadPtr(32'h6000);
    enable();
    waitStop("R11 stop");
    chk("R11 drained full FIFO", logW[lastStat(base)], 32'h8000_0040);
    chk("R10 packet consumed", 32'(fifoPktCnt), 0);

    // R10 packet end in the same cycle as packet completion
    sendBytes(5);
    endPkt();
    bufSize = 16'd64;
    loadPtr(32'h7000);
    enable();
    begin
      int t = 0;
      do begin @(posedge clk); #1; t++; end while (!(busReq && busOp == 2'd2) && t < 200);
    end
    @(negedge clk); macPktEnd = 1'b1;
    @(negedge clk); macPktEnd = 1'b0;
    chk("R10 simultaneous inc and dec", 32'(fifoPktCnt), 1);
    waitStop("R10 stop");
    base = logN;
    loadPtr(32'h7100);
    enable();
    waitStop("R10 cleanup stop");
    chk("R10 empty packet drained", logW[lastStat(base)], 32'h8000_0000);
    chk("R10 count back to zero", 32'(fifoPktCnt), 0);

    // R6 chained descriptors
    bufSize = 16'd32;
    base = logN;
    loadPtr(32'h1000);
    enable();
    sendBytes(6);
    endPkt();
    begin
      int t = 0;
      while (curDescPtr != 32'h2000 && t < 200) begin @(negedge clk); t++; end
    end
    chk("R6 pointer follows link", curDescPtr, 32'h2000);
    chk("R6 flag clear after link", 32'(descDone), 0);
    chk("R6 still enabled", 32'(rxEnabled), 1);
    sendBytes(7);
    endPkt();
    waitStop("R6 stop");
    chk("R6 next descriptor read op",   32'(logOp[base+3]), 0);
    chk("R6 next descriptor read addr", logAddr[base+3], 32'h2000);
    st = lastStat(base);
    chk("R6 second status address", logAddr[st], 32'h2004);
    chk("R6 second status word", logW[st], 32'h8000_0007);

    // R8 refresh with zero link
    base = logN;
    enable();
    waitStop("R8 stop");
    chk("R8 refresh op",     32'(logOp[base]), 1);
    chk("R8 refresh addr",   logAddr[base], 32'h2000);
    chk("R8 refresh len",    32'(logLen[base]), 4);
    chk("R8 single request", 32'(logN - base), 1);
    chk("R8 flag kept",      32'(descDone), 1);

    // R8 refresh with appended descriptor
    extraLink = 32'h3000;
    base = logN;
    enable();
    sendBytes(3);
    endPkt();
    waitStop("R8 append stop");
    chk("R8 refresh op again",      32'(logOp[base]), 1);
    chk("R8 appended desc read",    logAddr[base+1], 32'h3000);
    chk("R8 pointer loaded",        curDescPtr, 32'h3000);
    st = lastStat(base);
    chk("R8 appended status addr",  logAddr[st], 32'h3004);
    chk("R8 appended status word",  logW[st], 32'h8000_0003);

    // R9 pointer write with flag set
    chk("R9 flag set before write", 32'(descDone), 1);
    loadPtr(32'h8000);
    chk("R9 flag cleared", 32'(descDone), 0);
    chk("R9 pointer loaded", curDescPtr, 32'h8000);
    chk("R9 no request",  32'(busReq), 0);

    summary();
    $finish;
  end
endmodule